// File: doc/BRIEF.md
# Serial Configuration Slave with Block Transfers

This block is a two-wire serial slave that keeps two 8-bit configuration registers for a clock generator and turns selected bits into control lines. Every access first names a starting register index. A write then gives a byte count, and the data bytes that follow fill consecutive registers. A read changes direction with a repeated start. The slave then sends how many bytes remain from the chosen index, followed by the register contents, until the master declines a byte.

Both bus lines are sampled in the system clock domain. Each line passes through a two-flop synchronizer and then a filter that requires a run of equal samples. Start and stop conditions are SDA edges seen while SCL is high. Either one returns the slave to address reception, wherever the transfer stands.

Three control outputs come from the registers. The first is a secondary-generator enable. The second is a line that picks the 48 MHz or the 72 MHz secondary mode. The third is a primary enable, which is kept permanently asserted.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, register 0 reads 6Fh and register 1 reads 3Fh, so `aux_en` is 1 and `aux_sel48` is 0.
- R2: A pulse on SDA shorter than `FILT_LEN` system clocks is filtered out. It neither starts nor aborts a transfer, nor does it corrupt one.
- R3: The slave answers only to the 7-bit address 6Ah, with the direction in bit 0: D4h writes and D5h reads. It does not acknowledge any other address, and it leaves SDA released until the next start.
- R4: A write runs as follows: address D4h, index N, count X, then X data bytes stored into registers N, N+1, and so on. The slave acknowledges each byte it accepts.
- R5: Register 0 bit 1 drives `aux_en`. Writing 55h to register 0 clears it.
- R6: Register 1 bit 7 drives `aux_sel48`, where 1 means 48 MHz mode. Writing BFh sets it.
- R7: Register 0 bit 0 always reads 1 and `main_en` stays 1, whatever is written to that bit.
- R8: An index above 1 is not acknowledged. A count of 0 or a count above 2 is not acknowledged either.
- R9: A data byte beyond the declared count, or one that would land past register 1, is not acknowledged and changes nothing.
- R10: A read runs as follows: index N, repeated start, D5h. The slave sends the count 2-N and then the registers from N upward. It moves to the next byte on the master's acknowledge and releases the bus after a not-acknowledge.
- R11: A start received mid-transfer abandons that transfer and begins a new address phase.
- R12: The slave changes its SDA drive only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| cfg0 | output | 8 | Register 0 contents |
| cfg1 | output | 8 | Register 1 contents |
| main_en | output | 1 | Primary generator enable, always 1 |
| aux_en | output | 1 | Secondary generator enable |
| aux_sel48 | output | 1 | Secondary frequency select, 1 is 48 MHz |

## Verification
Single-byte and two-byte writes starting at each index show that the index and the count steer the data to the right registers. Reads from both indices separate the returned count from the register data and check that the transfer ends on the master's not-acknowledge. Out-of-range indices and counts, surplus data bytes and a foreign address each show whether a byte is refused without side effects. A restarted write and a short SDA pulse inside a data bit distinguish a real start from noise that the filter should absorb.

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h6A,
  parameter int         FILT_LEN = 3,
  parameter logic [7:0] RST0     = 8'h6F,
  parameter logic [7:0] RST1     = 8'h3F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] cfg0,
  output logic [7:0] cfg1,
  output logic       main_en,
  output logic       aux_en,
  output logic       aux_sel48
);

  localparam logic [1:0] NREG = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_INDEX, S_COUNT, S_WDATA, S_TXCNT, S_TXDAT} st_t;

  logic [1:0]          scl_s, sda_s;
  logic [FILT_LEN-1:0] scl_h, sda_h;
  logic                scl_f, sda_f, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1;
      scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1;
      scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_h <= {scl_h[FILT_LEN-2:0], scl_s[1]};
      sda_h <= {sda_h[FILT_LEN-2:0], sda_s[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  wire start_c  = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_c   = scl_f & scl_q & ~sda_q & sda_f;
  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;

  st_t        st, nxt_st;
  logic [3:0] bitn;
  logic [7:0] shreg, txsh;
  logic       in_ack, ack_drv, mack;
  logic [1:0] ptr, remain;

  wire        tx_st   = (st == S_TXCNT) || (st == S_TXDAT);
  wire [7:0]  rd_byte = (ptr == 2'd0) ? cfg0 : (ptr == 2'd1) ? cfg1 : 8'hFF;
  wire        addr_hit = (shreg[7:1] == DEV_ADDR);
  wire        idx_ok   = (shreg < {6'd0, NREG});
  wire        cnt_ok   = (shreg != 8'd0) && (shreg <= {6'd0, NREG});
  wire        dat_ok   = (remain != 2'd0) && (ptr < NREG);

  assign sda_oe    = (in_ack & ack_drv) | (tx_st & ~in_ack & ~txsh[7]);
  assign main_en   = cfg0[0];
  assign aux_en    = cfg0[1];
  assign aux_sel48 = cfg1[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; nxt_st <= S_IDLE;
      bitn <= '0; shreg <= '0; txsh <= '1;
      in_ack <= 1'b0; ack_drv <= 1'b0; mack <= 1'b0;
      ptr <= '0; remain <= '0;
      cfg0 <= RST0 | 8'h01;
      cfg1 <= RST1;
    end else if (start_c) begin
      st <= S_ADDR; bitn <= '0; in_ack <= 1'b0; ack_drv <= 1'b0; txsh <= '1;
    end else if (stop_c) begin
      st <= S_IDLE; bitn <= '0; in_ack <= 1'b0; ack_drv <= 1'b0; txsh <= '1;
    end else begin
      case (st)
        S_IDLE: ;
        S_TXCNT, S_TXDAT: begin
          if (!in_ack) begin
            if (scl_fall) begin
              if (bitn == 4'd7) begin
                in_ack <= 1'b1;
                bitn   <= '0;
              end else begin
                txsh <= {txsh[6:0], 1'b1};
                bitn <= bitn + 4'd1;
              end
            end
          end else begin
            if (scl_rise) mack <= ~sda_f;
            if (scl_fall) begin
              in_ack <= 1'b0;
              if (mack) begin
                st   <= S_TXDAT;
                txsh <= rd_byte;
                if (ptr < NREG) ptr <= ptr + 2'd1;
              end else begin
                st   <= S_IDLE;
                txsh <= '1;
              end
            end
          end
        end
        default: begin
          if (!in_ack) begin
            if (scl_rise && bitn != 4'd8) begin
              shreg <= {shreg[6:0], sda_f};
              bitn  <= bitn + 4'd1;
            end
            if (scl_fall && bitn == 4'd8) begin
              in_ack <= 1'b1;
              bitn   <= '0;
              case (st)
                S_ADDR: begin
                  ack_drv <= addr_hit;
                  nxt_st  <= !addr_hit ? S_IDLE : (shreg[0] ? S_TXCNT : S_INDEX);
                end
                S_INDEX: begin
                  ack_drv <= idx_ok;
                  nxt_st  <= idx_ok ? S_COUNT : S_IDLE;
                  if (idx_ok) ptr <= shreg[1:0];
                end
                S_COUNT: begin
                  ack_drv <= cnt_ok;
                  nxt_st  <= cnt_ok ? S_WDATA : S_IDLE;
                  if (cnt_ok) remain <= shreg[1:0];
                end
                default: begin
                  ack_drv <= dat_ok;
                  nxt_st  <= S_WDATA;
                  if (dat_ok) begin
                    if (ptr == 2'd0) cfg0 <= {shreg[7:1], 1'b1};
                    else             cfg1 <= shreg;
                    ptr    <= ptr + 2'd1;
                    remain <= remain - 2'd1;
                  end
                end
              endcase
            end
          end else if (scl_fall) begin
            in_ack  <= 1'b0;
            ack_drv <= 1'b0;
            st      <= nxt_st;
            if (nxt_st == S_TXCNT) txsh <= 8'd2 - {6'd0, ptr};
          end
        end
      endcase
    end
  end

  AST_MAIN_EN_HELD: assert property (@(posedge clk) disable iff (!rst_n) main_en); // R7
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_f); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe); // R3
  AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg0 != $past(cfg0)) || (cfg1 != $past(cfg1))) |-> $past(st == S_WDATA)); // R9
  AST_TX_RELEASE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_st && in_ack) |-> !sda_oe); // R10

endmodule

// File: tb/tb_cfg_i2c_slave.sv
module tb_cfg_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int TQ = 15;
  localparam int TH = 20;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, main_en, aux_en, aux_sel48;
  logic [7:0] cfg0, cfg1;
  logic sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  cfg_i2c_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .cfg0(cfg0), .cfg1(cfg1), .main_en(main_en), .aux_en(aux_en), .aux_sel48(aux_sel48)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [7:0] val; string tag; } item_t;
  item_t      exp_q[$];
  logic [7:0] obs_val;
  event       obs_ev;
  int         checks = 0, errors = 0;

  initial forever begin
    item_t it;
    @(obs_ev);
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL unexpected observation act=%h exp=none", obs_val);
    end else begin
      it = exp_q.pop_front();
      checks++;
      if (obs_val !== it.val) begin
        errors++;
        $display("FAIL %s act=%h exp=%h", it.tag, obs_val, it.val);
      end
    end
  end

  task automatic expect_v(input logic [7:0] v, input string tag);
    item_t it;
    it.val = v; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic report(input logic [7:0] v);
    obs_val = v; ->obs_ev; #1;
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wt(TQ); scl_m = 1'b1; wt(TH); sda_m = 1'b0; wt(TH); scl_m = 1'b0; wt(TQ);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wt(TQ); scl_m = 1'b1; wt(TH); sda_m = 1'b1; wt(TH);
  endtask

  task automatic bit_w(input logic b, input logic glitch);
    sda_m = b; wt(TQ); scl_m = 1'b1;
    if (glitch && b) begin
      wt(TH/2); sda_m = 1'b0; wt(1); sda_m = 1'b1; wt(TH/2 - 1);
    end else wt(TH);
    scl_m = 1'b0; wt(TQ);
  endtask

  task automatic bit_r(output logic b);
    sda_m = 1'b1; wt(TQ); scl_m = 1'b1; wt(TH/2); b = sda_bus; wt(TH/2); scl_m = 1'b0; wt(TQ);
  endtask

  task automatic send(input logic [7:0] d, input logic exp_ack, input string tag, input logic glitch = 1'b0);
    logic b;
    for (int i = 7; i >= 0; i--) bit_w(d[i], glitch);
    bit_r(b);
    expect_v({7'd0, exp_ack}, tag);
    report({7'd0, ~b});
  endtask

  task automatic recv(input logic [7:0] exp_d, input logic m_ack, input string tag);
    logic [7:0] d;
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_r(b); d[i] = b; end
    bit_w(~m_ack, 1'b0);
    expect_v(exp_d, tag);
    report(d);
  endtask

  task automatic chk_regs(input logic [7:0] e0, input logic [7:0] e1, input string tag);
    wt(4);
    expect_v(e0, {tag, " cfg0"}); report(cfg0);
    expect_v(e1, {tag, " cfg1"}); report(cfg1);
    expect_v({5'd0, 1'b1, e0[1], e1[7]}, {tag, " enables"});
    report({5'd0, main_en, aux_en, aux_sel48});
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    errors++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wt(5); rst_n = 1'b1; wt(10);
    chk_regs(8'h6F, 8'h3F, "R1 reset");

    i2c_start(); send(8'hD4, 1, "R3 addr ack"); send(8'h00, 1, "R4 index");
    send(8'h01, 1, "R4 count"); send(8'h55, 1, "R4 data"); i2c_stop();
    chk_regs(8'h55, 8'h3F, "R5 aux off");

    i2c_start(); send(8'hD4, 1, "R4 addr"); send(8'h01, 1, "R4 index1");
    send(8'h01, 1, "R4 count"); send(8'hBF, 1, "R6 data"); i2c_stop();
    chk_regs(8'h55, 8'hBF, "R6 sel48");

    i2c_start(); send(8'hD4, 1, "R4 addr"); send(8'h00, 1, "R4 index");
    send(8'h02, 1, "R4 count2"); send(8'h6C, 1, "R7 data0"); send(8'h3E, 1, "R4 data1"); i2c_stop();
    chk_regs(8'h6D, 8'h3E, "R7 bit0 held");

    i2c_start(); send(8'hD4, 1, "R10 addr"); send(8'h00, 1, "R10 index");
    i2c_start(); send(8'hD5, 1, "R10 rd addr");
    recv(8'h02, 1, "R10 count N0"); recv(8'h6D, 1, "R10/R12 reg0"); recv(8'h3E, 0, "R10/R12 reg1");
    i2c_stop();

    i2c_start(); send(8'hD4, 1, "R10 addr"); send(8'h01, 1, "R10 index1");
    i2c_start(); send(8'hD5, 1, "R10 rd addr");
    recv(8'h01, 1, "R10 count N1"); recv(8'h3E, 0, "R10 reg1"); i2c_stop();

    i2c_start(); send(8'hD4, 1, "R8 addr"); send(8'h02, 0, "R8 index2 nack"); i2c_stop();
    i2c_start(); send(8'hD4, 1, "R8 addr"); send(8'h00, 1, "R8 index");
    send(8'h00, 0, "R8 count0 nack"); i2c_stop();
    i2c_start(); send(8'hD4, 1, "R8 addr"); send(8'h00, 1, "R8 index");
    send(8'h03, 0, "R8 count3 nack"); i2c_stop();
    chk_regs(8'h6D, 8'h3E, "R8 unchanged");

    i2c_start(); send(8'hD4, 1, "R9 addr"); send(8'h00, 1, "R9 index");
    send(8'h01, 1, "R9 count1"); send(8'h11, 1, "R9 data");
    send(8'h22, 0, "R9 surplus nack"); i2c_stop();
    chk_regs(8'h11, 8'h3E, "R9 surplus dropped");
    i2c_start(); send(8'hD4, 1, "R9 addr"); send(8'h01, 1, "R9 index1");
    send(8'h02, 1, "R9 count2"); send(8'h44, 1, "R9 data");
    send(8'h55, 0, "R9 past end nack"); i2c_stop();
    chk_regs(8'h11, 8'h44, "R9 past end dropped");

    i2c_start(); send(8'hA0, 0, "R3 foreign nack"); send(8'h00, 0, "R3 still silent"); i2c_stop();
    chk_regs(8'h11, 8'h44, "R3 foreign unchanged");

    i2c_start(); send(8'hD4, 1, "R11 addr"); send(8'h00, 1, "R11 index");
    send(8'h02, 1, "R11 count");
    i2c_start(); send(8'hD4, 1, "R11 restart addr"); send(8'h01, 1, "R11 index1");
    send(8'h01, 1, "R11 count1"); send(8'h9A, 1, "R11 data"); i2c_stop();
    chk_regs(8'h11, 8'h9A, "R11 restart");

    i2c_start(); send(8'hD4, 1, "R2 addr"); send(8'h00, 1, "R2 index");
    send(8'h01, 1, "R2 count"); send(8'h7D, 1, "R2 glitched data", 1'b1); i2c_stop();
    chk_regs(8'h7D, 8'h9A, "R2 glitch filtered");

    wt(20);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard leftover act=%0d exp=0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule